// File: doc/BRIEF.md
# Sectored Flash Program and Erase Sequencer

This block is the embedded controller of a small sectored NOR flash. It takes already-decoded requests (program one word, erase a set of sectors, erase the whole chip, suspend an erase, resume it) and runs them against a plain single-port array. The array port has a read address, a write strobe whose effect is to clear bits (`stored & wdata`), and one erase strobe per sector that sets every word of that sector to all ones. A down-counting timer sets the length of each program or erase pulse. After each pulse the sequencer reads the array back to verify the result, and it repeats the pulse until the verify passes.

An erase first programs to zero every word of the selected sectors that is not already zero. Only then does it strobe the erase lines, and it scans the sectors afterwards to confirm they read all ones. While an operation is running, a read returns a status word instead of array data. Progress is also shown on the `ready` output. The seven sectors follow either a top-boot or a bottom-boot map. Protected sectors are left alone, except while the temporary-unprotect input is high. No command starts while `vcc_low` is high.

States: `ST_READ` (idle), `ST_PROG_PULSE`, `ST_PROG_VERIFY`, `ST_PRE_CHECK`, `ST_PRE_PULSE`, `ST_ERA_PULSE`, `ST_ERA_VERIFY` and `ST_SUSPEND`. The transitions are:

- `ST_READ` to `ST_PROG_PULSE` on a program request that is accepted.
- `ST_PROG_PULSE` to `ST_PROG_VERIFY` when the timer expires.
- `ST_PROG_VERIFY` to `ST_READ` on a match, or back to `ST_PROG_PULSE` on a mismatch.
- `ST_READ` to `ST_PRE_CHECK` on an erase request that is accepted.
- `ST_PRE_CHECK` to `ST_PRE_PULSE` on a selected word that is not zero, and to `ST_ERA_PULSE` after the last address.
- `ST_PRE_PULSE` to `ST_PRE_CHECK` when the timer expires.
- `ST_ERA_PULSE` to `ST_ERA_VERIFY` when the timer expires.
- `ST_ERA_VERIFY` to `ST_ERA_PULSE` on a selected word that is not all ones, and to `ST_READ` after the last address.
- Any of the four erase-phase states to `ST_SUSPEND` on suspend.
- `ST_SUSPEND` to the saved state on resume.

Top module: `flash_seq`

## Requirements
- R1: While `rst_n` is low (active-low, asynchronous), the block is in read mode. In read mode `ready` is 1, `arr_wr` is 0 and `arr_erase` is 0, and this holds even when reset arrives in the middle of an erase.
- R2: Command code 0 programs `cmd_data` at `cmd_addr`. The block raises `arr_wr` for exactly PROG_CYCLES cycles, verifies the word, and returns to read mode on its own. A later read of that address returns `cmd_data`.
- R3: While busy, a read returns a status word whose bit 7 is the complement of bit 7 of the target data. The target for a program is `cmd_data[7]`, and the target for an erase is 1, so bit 7 reads 0 during an erase.
- R4: While busy, bit 6 of the status word inverts between successive status reads. All status bits other than 7 and 6 are 0.
- R5: `ready` goes low in the cycle after an accepted command and stays low until the operation ends.
- R6: Command code 1 erases the sectors whose bits are set in `cmd_sectors`, where bit i is the i-th sector in ascending address order. Each selected word ends at all ones, and words outside those sectors keep their value.
- R7: Before the first erase strobe, every word of the selected sectors holds zero. `arr_wr` and `arr_erase` are never active together.
- R8: Command code 2 erases all seven sectors, except those that are protected.
- R9: Sector starts are given in word units of UNIT. The top-boot map uses 0, 8, 16, 24, 28, 29 and 30, and memory ends at 32. The bottom-boot map uses 0, 2, 3, 4, 8, 16 and 24. The map is chosen by TOP_BOOT.
- R10: A set bit of `prot_mask` keeps its sector out of every operation. A program request aimed at that sector is ignored, and `ready` stays 1. Setting `unprot_tmp` to 1 lifts protection for as long as it is held.
- R11: While `vcc_low` is 1, program and erase requests are ignored.
- R12: Command code 3 during an erase enters suspend, and `ready` is 1 from the next cycle. While suspended, no strobes are active, and reads of sectors outside the erase return array data. Reads of a sector under erase return the status word. Command code 4 resumes the erase, which then runs to completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume |
| cmd_addr | input | AW | Word address for program |
| cmd_data | input | DW | Data to program |
| cmd_sectors | input | 7 | Sector selection for sector erase |
| prot_mask | input | 7 | Per-sector protection |
| unprot_tmp | input | 1 | Temporary override of protection |
| vcc_low | input | 1 | Supply-low indicator; blocks commands |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read word address |
| rd_data | output | DW | Read result, valid the cycle after `rd_en` |
| ready | output | 1 | 1 = ready (idle or suspended), 0 = busy |
| arr_addr | output | AW | Array address |
| arr_wr | output | 1 | Array program strobe |
| arr_wdata | output | DW | Array program data |
| arr_rdata | input | DW | Array read data at `arr_addr` |
| arr_erase | output | 7 | Per-sector erase strobes |

## Verification
The hardest situation to reach is a suspend that lands in the middle of an erase, followed by reads from both a foreign sector and the sector being erased, and then a resume. The stimulus first fills the target sector with words that are not zero, so that the preprogram scan takes hundreds of cycles. It waits a fixed number of cycles, issues the suspend, reads both sectors, and then resumes. A second hard case is showing that preprogramming finished before erasure began. The bench model watches for the first cycle with an erase strobe and inspects the selected words before the strobe takes effect.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    localparam int NSEC = 7;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_SERASE = 3'd1,
        OP_CERASE = 3'd2,
        OP_SUSP   = 3'd3,
        OP_RESUME = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_READ,
        ST_PROG_PULSE,
        ST_PROG_VERIFY,
        ST_PRE_CHECK,
        ST_PRE_PULSE,
        ST_ERA_PULSE,
        ST_ERA_VERIFY,
        ST_SUSPEND
    } state_e;

    // Sector size in allocation units (one unit = 1/32 of the array).
    function automatic int unsigned sec_units(int idx, bit top);
        int k;
        k = top ? idx : (NSEC - 1 - idx);
        case (k)
            0, 1, 2: return 8;
            3:       return 4;
            4, 5:    return 1;
            default: return 2;
        endcase
    endfunction

    function automatic int unsigned sec_start(int idx, bit top);
        int unsigned s;
        s = 0;
        for (int k = 0; k < idx; k++) s += sec_units(k, top);
        return s;
    endfunction

endpackage

// File: rtl/flash_sector_map.sv
module flash_sector_map
    import flash_seq_pkg::*;
#(
    parameter int UNIT     = 4,
    parameter bit TOP_BOOT = 1'b1,
    localparam int AW      = $clog2(32 * UNIT)
) (
    input  logic [AW-1:0]   addr,
    output logic [NSEC-1:0] hit
);
    for (genvar i = 0; i < NSEC; i++) begin : g_sec
        localparam int unsigned LO = UNIT * sec_start(i, TOP_BOOT);
        localparam int unsigned HI = LO + UNIT * sec_units(i, TOP_BOOT);
        assign hit[i] = ({1'b0, addr} >= (AW+1)'(LO)) && ({1'b0, addr} < (AW+1)'(HI));
    end
endmodule

// File: rtl/flash_pulse_timer.sv
module flash_pulse_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= len;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == CW'(1));
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import flash_seq_pkg::*;
#(
    parameter int DW           = 16,
    parameter int UNIT         = 4,
    parameter bit TOP_BOOT     = 1'b1,
    parameter int PROG_CYCLES  = 8,
    parameter int ERASE_CYCLES = 64,
    localparam int DEPTH       = 32 * UNIT,
    localparam int AW          = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic [6:0]    cmd_sectors,
    input  logic [6:0]    prot_mask,
    input  logic          unprot_tmp,
    input  logic          vcc_low,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          ready,
    output logic [AW-1:0] arr_addr,
    output logic          arr_wr,
    output logic [DW-1:0] arr_wdata,
    input  logic [DW-1:0] arr_rdata,
    output logic [6:0]    arr_erase
);
    localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    state_e        state_q, state_d, saved_q;
    logic [AW-1:0] op_addr_q, scan_q;
    logic [DW-1:0] op_data_q, rd_data_q;
    logic [6:0]    sel_q, allowed, req_mask, cmd_hit, scan_hit, rd_hit;
    logic          tgt7_q, toggle_q;
    logic          tstart, tdone, latch_prog, latch_erase, scan_inc, scan_clr, save;
    logic [CW-1:0] tlen;
    logic          scan_last, scan_sel, erase_phase;
    op_e           op;

    assign op          = op_e'(cmd_op);
    assign allowed     = ~(prot_mask & {7{~unprot_tmp}});
    assign req_mask    = (op == OP_CERASE) ? 7'h7F : cmd_sectors;
    assign scan_last   = (scan_q == AW'(DEPTH - 1));
    assign scan_sel    = |(scan_hit & sel_q);
    assign erase_phase = (state_q == ST_PRE_CHECK) || (state_q == ST_PRE_PULSE) ||
                         (state_q == ST_ERA_PULSE) || (state_q == ST_ERA_VERIFY);

    flash_sector_map #(.UNIT(UNIT), .TOP_BOOT(TOP_BOOT)) u_map_cmd  (.addr(cmd_addr), .hit(cmd_hit));
    flash_sector_map #(.UNIT(UNIT), .TOP_BOOT(TOP_BOOT)) u_map_scan (.addr(scan_q),   .hit(scan_hit));
    flash_sector_map #(.UNIT(UNIT), .TOP_BOOT(TOP_BOOT)) u_map_rd   (.addr(rd_addr),  .hit(rd_hit));

    flash_pulse_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tstart), .len(tlen), .done(tdone)
    );

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        tstart      = 1'b0;
        tlen        = CW'(PROG_CYCLES);
        latch_prog  = 1'b0;
        latch_erase = 1'b0;
        scan_inc    = 1'b0;
        scan_clr    = 1'b0;
        save        = 1'b0;
        unique case (state_q)
            ST_READ: begin
                if (cmd_valid && !vcc_low) begin
                    if (op == OP_PROG && |(cmd_hit & allowed)) begin
                        latch_prog = 1'b1;
                        tstart     = 1'b1;
                        state_d    = ST_PROG_PULSE;
                    end else if ((op == OP_SERASE || op == OP_CERASE) && |(req_mask & allowed)) begin
                        latch_erase = 1'b1;
                        scan_clr    = 1'b1;
                        state_d     = ST_PRE_CHECK;
                    end
                end
            end
            ST_PROG_PULSE: if (tdone) state_d = ST_PROG_VERIFY;
            ST_PROG_VERIFY: begin
                if (arr_rdata == op_data_q) state_d = ST_READ;
                else begin
                    tstart  = 1'b1;
                    state_d = ST_PROG_PULSE;
                end
            end
            ST_PRE_CHECK: begin
                if (scan_sel && arr_rdata != '0) begin
                    tstart  = 1'b1;
                    state_d = ST_PRE_PULSE;
                end else if (scan_last) begin
                    tstart  = 1'b1;
                    tlen    = CW'(ERASE_CYCLES);
                    state_d = ST_ERA_PULSE;
                end else scan_inc = 1'b1;
            end
            ST_PRE_PULSE: if (tdone) state_d = ST_PRE_CHECK;
            ST_ERA_PULSE: begin
                if (tdone) begin
                    scan_clr = 1'b1;
                    state_d  = ST_ERA_VERIFY;
                end
            end
            ST_ERA_VERIFY: begin
                if (scan_sel && arr_rdata != '1) begin
                    tstart  = 1'b1;
                    tlen    = CW'(ERASE_CYCLES);
                    state_d = ST_ERA_PULSE;
                end else if (scan_last) state_d = ST_READ;
                else scan_inc = 1'b1;
            end
            ST_SUSPEND: begin
                if (cmd_valid && op == OP_RESUME) begin
                    tstart  = 1'b1;
                    tlen    = (saved_q == ST_ERA_PULSE) ? CW'(ERASE_CYCLES) : CW'(PROG_CYCLES);
                    state_d = saved_q;
                end
            end
        endcase
        if (erase_phase && cmd_valid && op == OP_SUSP) begin
            save     = 1'b1;
            tstart   = 1'b0;
            scan_inc = 1'b0;
            scan_clr = 1'b0;
            state_d  = ST_SUSPEND;
        end
    end

    // State and operand registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_READ;
            saved_q   <= ST_READ;
            op_addr_q <= '0;
            op_data_q <= '0;
            sel_q     <= '0;
            tgt7_q    <= 1'b0;
            scan_q    <= '0;
        end else begin
            state_q <= state_d;
            if (save) saved_q <= state_q;
            if (latch_prog) begin
                op_addr_q <= cmd_addr;
                op_data_q <= cmd_data;
                tgt7_q    <= cmd_data[7];
            end
            if (latch_erase) begin
                sel_q  <= req_mask & allowed;
                tgt7_q <= 1'b1;
            end
            if (scan_clr)      scan_q <= '0;
            else if (scan_inc) scan_q <= scan_q + 1'b1;
        end
    end

    // Read path with status word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
            toggle_q  <= 1'b0;
        end else if (rd_en) begin
            if (state_q == ST_READ || (state_q == ST_SUSPEND && !(|(rd_hit & sel_q)))) begin
                rd_data_q <= arr_rdata;
            end else begin
                rd_data_q    <= '0;
                rd_data_q[7] <= ~tgt7_q;
                rd_data_q[6] <= toggle_q;
                if (!ready) toggle_q <= ~toggle_q;
            end
        end
    end

    // Outputs
    always_comb begin
        ready     = (state_q == ST_READ) || (state_q == ST_SUSPEND);
        arr_wr    = (state_q == ST_PROG_PULSE) || (state_q == ST_PRE_PULSE);
        arr_wdata = (state_q == ST_PROG_PULSE) ? op_data_q : '0;
        arr_erase = (state_q == ST_ERA_PULSE) ? sel_q : '0;
        if (state_q == ST_PROG_PULSE || state_q == ST_PROG_VERIFY) arr_addr = op_addr_q;
        else if (ready)                                            arr_addr = rd_addr;
        else                                                       arr_addr = scan_q;
        rd_data   = rd_data_q;
    end

    assert_wr_erase_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_wr && (arr_erase != '0)));
    assert_ready_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (!arr_wr && arr_erase == '0));
    assert_vcc_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && cmd_valid && vcc_low) |=> ready);
    assert_prot_prog_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && cmd_valid && op == OP_PROG && !(|(cmd_hit & allowed))) |=> (state_q == ST_READ));
    assert_suspend_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_phase && cmd_valid && op == OP_SUSP) |=> ready);
    assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(cmd_valid));
endmodule

// File: tb/flash_seq_bench.sv
module flash_seq_bench;
    localparam int DW = 16, UNIT = 4, PROG = 8, ERA = 64;
    localparam int DEPTH = 32 * UNIT, AW = $clog2(DEPTH);
    // Top-boot sector starts from R9, in words, with the end of memory last.
    localparam int START [8] = '{0, 8*UNIT, 16*UNIT, 24*UNIT, 28*UNIT, 29*UNIT, 30*UNIT, 32*UNIT};

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, unprot_tmp = 1'b0, vcc_low = 1'b0, rd_en = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, rd_addr = '0, arr_addr;
    logic [DW-1:0] cmd_data = '0, rd_data, arr_wdata, arr_rdata;
    logic [6:0] cmd_sectors = '0, prot_mask = '0, arr_erase;
    logic ready, arr_wr;

    logic [DW-1:0] mem [DEPTH];
    int checks = 0, fails = 0, wr_cycles = 0, cyc = 0;
    bit erase_seen = 0, pre_ok = 0;

    always #2 clk = ~clk;

    flash_seq #(.DW(DW), .UNIT(UNIT), .TOP_BOOT(1'b1), .PROG_CYCLES(PROG), .ERASE_CYCLES(ERA)) u_flash_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .cmd_sectors(cmd_sectors), .prot_mask(prot_mask), .unprot_tmp(unprot_tmp),
        .vcc_low(vcc_low), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready),
        .arr_addr(arr_addr), .arr_wr(arr_wr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .arr_erase(arr_erase));

    function automatic int sec_of(int a);
        for (int s = 0; s < 7; s++) if (a >= START[s] && a < START[s+1]) return s;
        return 0;
    endfunction

    // Array model: program clears bits, erase sets a sector to ones.
    assign arr_rdata = mem[arr_addr];
    always @(posedge clk) begin
        if (arr_wr) mem[arr_addr] <= mem[arr_addr] & arr_wdata;
        for (int a = 0; a < DEPTH; a++) if (arr_erase[sec_of(a)]) mem[a] <= '1;
    end

    // Monitor sampled away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (arr_wr) wr_cycles++;
        if (arr_erase != '0 && !erase_seen) begin
            erase_seen = 1;
            pre_ok = 1;
            for (int a = 0; a < DEPTH; a++) if (arr_erase[sec_of(a)] && mem[a] != '0) pre_ok = 0;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(int op, int addr, int data, int mask);
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(addr); cmd_data = DW'(data); cmd_sectors = 7'(mask);
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic rd(int addr, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1; rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
    endtask

    task automatic wait_ready(string req);
        int n = 0;
        while (!ready && n < 20000) begin @(negedge clk); n++; end
        check(ready, req, ready, 1);
    endtask

    task automatic fill(int lo, int hi, logic [DW-1:0] v);
        for (int a = lo; a < hi; a++) mem[a] = v;
    endtask

    task automatic t_reset();
        check(ready == 1, "R1 ready", ready, 1);
        check(arr_wr == 0 && arr_erase == 0, "R1 strobes", {arr_wr, arr_erase}, 0);
    endtask

    task automatic t_program();
        logic [DW-1:0] s1, s2, d;
        fill(0, DEPTH, '1);
        wr_cycles = 0;
        issue(0, 40, 16'h1234, 0);
        check(ready == 0, "R5 busy", ready, 0);
        rd(40, s1); rd(40, s2);
        check(s1[7] == 1'b1, "R3 poll prog", s1[7], 1);
        check(s1[6] != s2[6], "R4 toggle", s2[6], ~s1[6]);
        check((s1 & 16'hFF3F) == 0, "R4 other bits", s1, 0);
        wait_ready("R2 complete");
        check(wr_cycles == PROG, "R2 pulse", wr_cycles, PROG);
        rd(40, d);
        check(d == 16'h1234, "R2 data", d, 16'h1234);
        issue(0, 41, 16'h00A5, 0);
        rd(41, s1);
        check(s1[7] == 1'b0, "R3 poll prog 1", s1[7], 0);
        wait_ready("R2 complete 2");
        check(mem[41] == 16'h00A5, "R2 data 2", mem[41], 16'h00A5);
    endtask

    task automatic t_erase();
        logic [DW-1:0] s;
        bit ok = 1;
        fill(0, DEPTH, 16'h5A5A);
        erase_seen = 0;
        issue(1, 0, 0, 7'b0110000);
        rd(0, s);
        check(s[7] == 1'b0, "R3 poll erase", s[7], 0);
        wait_ready("R6 complete");
        check(pre_ok, "R7 preprogram", pre_ok, 1);
        for (int a = START[4]; a < START[6]; a++) if (mem[a] != '1) ok = 0;
        check(ok, "R6 erased", ok, 1);
        check(mem[START[4]-1] == 16'h5A5A, "R9 lower edge", mem[START[4]-1], 16'h5A5A);
        check(mem[START[6]] == 16'h5A5A, "R9 upper edge", mem[START[6]], 16'h5A5A);
    endtask

    task automatic t_chip_protect();
        bit ok = 1, kept = 1;
        fill(0, DEPTH, 16'h0F0F);
        prot_mask = 7'b0000100;
        issue(2, 0, 0, 0);
        wait_ready("R8 complete");
        for (int a = 0; a < DEPTH; a++) begin
            if (sec_of(a) == 2) begin if (mem[a] != 16'h0F0F) kept = 0; end
            else if (mem[a] != '1) ok = 0;
        end
        check(ok, "R8 chip erased", ok, 1);
        check(kept, "R10 erase skips", kept, 1);
        mem[70] = '1;
        issue(0, 70, 16'h1111, 0);
        check(ready == 1, "R10 prog ignored", ready, 1);
        check(mem[70] == 16'hFFFF, "R10 cell kept", mem[70], 16'hFFFF);
        unprot_tmp = 1;
        issue(0, 70, 16'h1111, 0);
        check(ready == 0, "R10 unprotect busy", ready, 0);
        wait_ready("R10 unprotect done");
        check(mem[70] == 16'h1111, "R10 unprotect data", mem[70], 16'h1111);
        unprot_tmp = 0; prot_mask = '0;
    endtask

    task automatic t_vcc();
        fill(0, DEPTH, '1);
        vcc_low = 1;
        issue(0, 10, 16'h0000, 0);
        check(ready == 1, "R11 prog ignored", ready, 1);
        issue(2, 0, 0, 0);
        check(ready == 1, "R11 erase ignored", ready, 1);
        check(mem[10] == 16'hFFFF, "R11 cell kept", mem[10], 16'hFFFF);
        vcc_low = 0;
    endtask

    task automatic t_suspend();
        logic [DW-1:0] d, s;
        bit ok = 1;
        fill(0, DEPTH, 16'h1234);
        mem[40] = 16'hABCD;
        issue(1, 0, 0, 7'b0000001);
        repeat (20) @(negedge clk);
        issue(3, 0, 0, 0);
        check(ready == 1, "R12 suspended", ready, 1);
        check(arr_wr == 0 && arr_erase == 0, "R12 quiet", {arr_wr, arr_erase}, 0);
        rd(40, d);
        check(d == 16'hABCD, "R12 foreign read", d, 16'hABCD);
        rd(5, s);
        check(s[7] == 1'b0, "R12 status read", s[7], 0);
        repeat (10) @(negedge clk);
        check(ready == 1, "R12 holds", ready, 1);
        issue(4, 0, 0, 0);
        check(ready == 0, "R12 resumed", ready, 0);
        wait_ready("R12 complete");
        for (int a = START[0]; a < START[1]; a++) if (mem[a] != '1) ok = 0;
        check(ok, "R12 sector erased", ok, 1);
        check(mem[40] == 16'hABCD, "R12 other kept", mem[40], 16'hABCD);
    endtask

    task automatic t_hwreset();
        fill(0, DEPTH, '1);
        issue(2, 0, 0, 0);
        repeat (10) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(ready == 1, "R1 reset mid-erase", ready, 1);
        check(arr_wr == 0 && arr_erase == 0, "R1 reset quiet", {arr_wr, arr_erase}, 0);
        rst_n = 1;
    endtask

    initial begin
        fill(0, DEPTH, '1);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_chip_protect();
        t_vcc();
        t_suspend();
        t_hwreset();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule